// File: doc/BRIEF.md
# Three-Wire SLIP Link Framer with Parity UART

This block carries framed packets over a two-wire serial link (one data line in each direction, no handshake lines). On the transmit side a payload stream, presented one byte at a time with a marker on its final byte, is wrapped into a frame. The frame opens with a delimiter. Each payload byte follows, with any byte that collides with the delimiter or the escape code replaced by a two-byte escape. A checksum byte, escaped the same way, comes next, and a closing delimiter ends the frame. Every resulting byte is sent as one serial character carrying even parity.

On the receive side, serial characters are recovered and their parity and stop bit are checked. Delimiters and escapes are stripped and the checksum is verified. Payload bytes are handed out in order, without the checksum byte. When the closing delimiter arrives, a one-cycle end pulse is raised together with a verdict. The verdict is either a good frame or one or more error causes: a bad character, a bad escape, a checksum mismatch or an overlong payload. After any error, the receiver drops everything up to the next delimiter.

Top module: `slip_uart_link`

## Requirements
- R1: Each serial character is a low start bit, 8 data bits least significant first, an even parity bit (data plus parity holds an even number of ones) and one high stop bit, each bit lasting CLKS_PER_BIT clocks; the idle line is high.
- R2: A transmitted frame is the delimiter 0xC0, the escaped payload bytes in order, the escaped checksum byte, and a closing 0xC0.
- R3: Inside a frame the data byte 0xC0 is carried as 0xDB 0xDC and the data byte 0xDB as 0xDB 0xDD, for payload and checksum alike; the receiver restores the original byte.
- R4: The checksum is the 8-bit two's complement of the modulo-256 sum of the payload bytes; a received frame passes only when all its unescaped bytes, checksum included, sum to zero, and the checksum byte is never delivered as payload.
- R5: A payload byte is taken on a clock where tx_valid and tx_ready are both high; tx_ready is high only while the frame body is open and the serializer is free, and tx_last on the taken byte ends the payload.
- R6: Received payload bytes appear on rx_data with single-cycle rx_valid pulses in arrival order; at the closing delimiter rx_frame_end pulses for one cycle and rx_frame_ok and the four error flags hold the verdict until the next frame end.
- R7: A character with bad parity or a low stop bit sets rx_err_char, marks the frame bad, and no further payload of that frame is delivered; reception resumes cleanly at the next 0xC0.
- R8: 0xDB followed by anything other than 0xDC or 0xDD sets rx_err_escape and marks the frame bad.
- R9: A checksum mismatch in a frame free of character and escape errors sets rx_err_checksum and clears rx_frame_ok.
- R10: Delimiters with nothing between them produce no frame end and no payload.
- R11: Of a payload longer than MAX_LEN bytes only the first MAX_LEN are delivered, and rx_err_length is set at the frame end.
- R12: After reset, received bytes ahead of the first 0xC0 are discarded.
- R13: During and just after reset, serial_out is high, tx_ready is low and no receive pulse is raised.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_data | input | 8 | Payload byte to send |
| tx_valid | input | 1 | tx_data holds a byte |
| tx_last | input | 1 | Current byte is the final payload byte |
| tx_ready | output | 1 | Byte is taken this clock when tx_valid is high |
| serial_out | output | 1 | Serial transmit line |
| serial_in | input | 1 | Serial receive line |
| rx_data | output | 8 | Received payload byte |
| rx_valid | output | 1 | rx_data holds a new byte this cycle |
| rx_frame_end | output | 1 | One-cycle pulse at a closed non-empty frame |
| rx_frame_ok | output | 1 | Last closed frame was good |
| rx_err_char | output | 1 | Last frame had a parity or stop-bit error |
| rx_err_escape | output | 1 | Last frame had an invalid escape |
| rx_err_checksum | output | 1 | Last frame failed the checksum |
| rx_err_length | output | 1 | Last frame's payload exceeded MAX_LEN |

## Verification
The bench aims at the escape cases: payload bytes equal to 0xC0 and 0xDB, and a payload whose checksum itself comes out as 0xC0. A design that escaped only payload would emit a bare delimiter mid-frame and split the frame. Receive tests corrupt one character's parity, insert an illegal escape, send a wrong checksum and an overlong payload. They also check that a design which kept delivering after an error, counted the checksum as payload or failed to truncate would show extra or missing bytes. Runs of bare delimiters and a stray byte after reset must raise no frame end, and a loopback frame checks that both directions agree.

// File: rtl/slip_link_pkg.sv
`timescale 1ns/1ps
// Shared codes, helper functions and state types for the SLIP link.
// Assumes 8-bit bytes throughout.
package slip_link_pkg;

    localparam logic [7:0] SLIP_DELIM    = 8'hC0;
    localparam logic [7:0] SLIP_ESCAPE   = 8'hDB;
    localparam logic [7:0] SLIP_TAIL_END = 8'hDC;
    localparam logic [7:0] SLIP_TAIL_ESC = 8'hDD;

    // True when a byte must be replaced by an escape pair inside a frame.
    function automatic logic needs_escape(input logic [7:0] b);
        return (b == SLIP_DELIM) || (b == SLIP_ESCAPE);
    endfunction

    // Second byte of the escape pair for a colliding byte.
    function automatic logic [7:0] escape_tail(input logic [7:0] b);
        return (b == SLIP_DELIM) ? SLIP_TAIL_END : SLIP_TAIL_ESC;
    endfunction

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_DATA,
        FR_DATA_TAIL,
        FR_SUM,
        FR_SUM_TAIL,
        FR_CLOSE
    } framer_state_t;

    typedef enum logic [1:0] {
        DF_HUNT,
        DF_BODY,
        DF_ESCAPE,
        DF_DISCARD
    } deframer_state_t;

    typedef struct packed {
        logic chr;
        logic esc;
        logic sum;
        logic len;
    } frame_err_t;

endpackage

// File: rtl/uart_tx_phy.sv
`timescale 1ns/1ps
// Serializer: sends one byte as start, 8 data bits LSB first, even parity,
// one stop bit. Accepts a byte whenever idle (in_ready high).
// Assumes CLKS_PER_BIT >= 2.
module uart_tx_phy #(
    parameter int CLKS_PER_BIT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    output logic       in_ready,
    output logic       line,
    output logic       busy
);
    localparam int CNT_W = $clog2(CLKS_PER_BIT);

    logic [CNT_W-1:0] baud_cnt;
    logic [9:0]       shreg;
    logic [3:0]       bits_left;

    assign in_ready = !busy;

    // Load a character when idle, then shift one bit per baud period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            line      <= 1'b1;
            baud_cnt  <= '0;
            shreg     <= '0;
            bits_left <= '0;
        end else if (!busy) begin
            if (in_valid) begin
                shreg     <= {1'b1, ^in_data, in_data};
                line      <= 1'b0;
                baud_cnt  <= '0;
                bits_left <= 4'd10;
                busy      <= 1'b1;
            end
        end else if (baud_cnt == CNT_W'(CLKS_PER_BIT - 1)) begin
            baud_cnt <= '0;
            if (bits_left == 4'd0) begin
                busy <= 1'b0;
                line <= 1'b1;
            end else begin
                line      <= shreg[0];
                shreg     <= {1'b0, shreg[9:1]};
                bits_left <= bits_left - 4'd1;
            end
        end else begin
            baud_cnt <= baud_cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/uart_rx_phy.sv
`timescale 1ns/1ps
// Deserializer: synchronizes the line, finds a start edge, samples every
// bit at its middle and checks even parity and the stop bit.
// Emits a one-cycle out_valid with out_err for a bad character.
module uart_rx_phy #(
    parameter int CLKS_PER_BIT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line,
    output logic [7:0] out_data,
    output logic       out_valid,
    output logic       out_err
);
    localparam int CNT_W = $clog2(CLKS_PER_BIT);
    localparam int HALF  = CLKS_PER_BIT / 2;

    logic             sync1, sync2;
    logic             running;
    logic [CNT_W-1:0] baud_cnt;
    logic [3:0]       bit_idx;
    logic [7:0]       shreg;
    logic             par_bit;
    logic [CNT_W-1:0] limit;

    assign limit = (bit_idx == 4'd0) ? CNT_W'(HALF - 1) : CNT_W'(CLKS_PER_BIT - 1);

    // Two-flop synchronizer for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= line;
            sync2 <= sync1;
        end
    end

    // Bit sampler: start check at half a bit, then one sample per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running   <= 1'b0;
            baud_cnt  <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            par_bit   <= 1'b0;
            out_data  <= '0;
            out_valid <= 1'b0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (!running) begin
                if (!sync2) begin
                    running  <= 1'b1;
                    baud_cnt <= '0;
                    bit_idx  <= '0;
                end
            end else if (baud_cnt == limit) begin
                baud_cnt <= '0;
                bit_idx  <= bit_idx + 4'd1;
                if (bit_idx == 4'd0) begin
                    if (sync2) running <= 1'b0;
                end else if (bit_idx <= 4'd8) begin
                    shreg <= {sync2, shreg[7:1]};
                end else if (bit_idx == 4'd9) begin
                    par_bit <= sync2;
                end else begin
                    running   <= 1'b0;
                    out_valid <= 1'b1;
                    out_data  <= shreg;
                    out_err   <= (par_bit != ^shreg) || !sync2;
                end
            end else begin
                baud_cnt <= baud_cnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/slip_framer.sv
`timescale 1ns/1ps
// Transmit framer: opens with a delimiter, escapes payload bytes, appends
// the escaped two's-complement checksum and closes with a delimiter.
// Feeds a byte sink that takes a byte when emit_valid and sink_ready.
module slip_framer
    import slip_link_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    input  logic       tx_last,
    output logic       tx_ready,
    input  logic       sink_ready,
    output logic [7:0] emit_byte,
    output logic       emit_valid
);
    framer_state_t state;
    logic [7:0]    sum_q;
    logic [7:0]    tail_q;
    logic          last_q;
    logic [7:0]    csum;
    logic          fire;

    assign csum = 8'h00 - sum_q;
    assign fire = emit_valid && sink_ready;

    // Select the byte to emit and whether payload is taken this cycle.
    always_comb begin
        emit_valid = 1'b0;
        emit_byte  = SLIP_DELIM;
        tx_ready   = 1'b0;
        unique case (state)
            FR_IDLE: begin
                emit_valid = tx_valid;
            end
            FR_DATA: begin
                emit_valid = tx_valid;
                emit_byte  = needs_escape(tx_data) ? SLIP_ESCAPE : tx_data;
                tx_ready   = sink_ready;
            end
            FR_DATA_TAIL, FR_SUM_TAIL: begin
                emit_valid = 1'b1;
                emit_byte  = tail_q;
            end
            FR_SUM: begin
                emit_valid = 1'b1;
                emit_byte  = needs_escape(csum) ? SLIP_ESCAPE : csum;
            end
            default: begin
                emit_valid = 1'b1;
            end
        endcase
    end

    // Advance through the frame each time a byte is handed to the sink.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= FR_IDLE;
            sum_q  <= '0;
            tail_q <= '0;
            last_q <= 1'b0;
        end else if (fire) begin
            unique case (state)
                FR_IDLE: begin
                    sum_q <= '0;
                    state <= FR_DATA;
                end
                FR_DATA: begin
                    sum_q <= sum_q + tx_data;
                    if (needs_escape(tx_data)) begin
                        tail_q <= escape_tail(tx_data);
                        last_q <= tx_last;
                        state  <= FR_DATA_TAIL;
                    end else begin
                        state <= tx_last ? FR_SUM : FR_DATA;
                    end
                end
                FR_DATA_TAIL: state <= last_q ? FR_SUM : FR_DATA;
                FR_SUM: begin
                    if (needs_escape(csum)) begin
                        tail_q <= escape_tail(csum);
                        state  <= FR_SUM_TAIL;
                    end else begin
                        state <= FR_CLOSE;
                    end
                end
                FR_SUM_TAIL: state <= FR_CLOSE;
                default:     state <= FR_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/slip_deframer.sv
`timescale 1ns/1ps
// Receive deframer: strips delimiters and escapes, holds back the newest
// byte so the checksum is never delivered, caps payload at MAX_LEN,
// and reports a verdict at each non-empty frame close.
// After an error all bytes are dropped until the next delimiter.
module slip_deframer
    import slip_link_pkg::*;
#(
    parameter int MAX_LEN = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] ch_data,
    input  logic       ch_valid,
    input  logic       ch_err,
    output logic [7:0] pay_data,
    output logic       pay_valid,
    output logic       end_pulse,
    output logic       frame_ok,
    output frame_err_t err_out
);
    localparam int LEN_W = $clog2(MAX_LEN + 1);

    deframer_state_t state, state_n;
    logic [7:0]      sum_q;
    logic [7:0]      held_q;
    logic            held_valid;
    logic [LEN_W-1:0] deliv_cnt;
    logic            have_any;
    logic            chr_q, esc_q, len_q;

    logic            dec_push;
    logic [7:0]      dec_data;
    logic            dec_close;
    logic            set_chr;
    logic            set_esc;
    logic            frame_bad;

    // Decode one received character against the current framing state.
    always_comb begin
        state_n   = state;
        dec_push  = 1'b0;
        dec_data  = ch_data;
        dec_close = 1'b0;
        set_chr   = 1'b0;
        set_esc   = 1'b0;
        if (ch_valid) begin
            unique case (state)
                DF_HUNT: begin
                    if (!ch_err && ch_data == SLIP_DELIM) state_n = DF_BODY;
                end
                DF_BODY: begin
                    if (ch_err) begin
                        set_chr = 1'b1;
                        state_n = DF_DISCARD;
                    end else if (ch_data == SLIP_DELIM) begin
                        dec_close = 1'b1;
                    end else if (ch_data == SLIP_ESCAPE) begin
                        state_n = DF_ESCAPE;
                    end else begin
                        dec_push = 1'b1;
                    end
                end
                DF_ESCAPE: begin
                    if (ch_err) begin
                        set_chr = 1'b1;
                        state_n = DF_DISCARD;
                    end else if (ch_data == SLIP_DELIM) begin
                        set_esc   = 1'b1;
                        dec_close = 1'b1;
                        state_n   = DF_BODY;
                    end else if (ch_data == SLIP_TAIL_END) begin
                        dec_push = 1'b1;
                        dec_data = SLIP_DELIM;
                        state_n  = DF_BODY;
                    end else if (ch_data == SLIP_TAIL_ESC) begin
                        dec_push = 1'b1;
                        dec_data = SLIP_ESCAPE;
                        state_n  = DF_BODY;
                    end else begin
                        set_esc = 1'b1;
                        state_n = DF_DISCARD;
                    end
                end
                default: begin
                    if (!ch_err && ch_data == SLIP_DELIM) begin
                        dec_close = 1'b1;
                        state_n   = DF_BODY;
                    end
                end
            endcase
        end
    end

    assign frame_bad = chr_q || esc_q || set_esc;

    // Accumulate, deliver held bytes, and close frames with a verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= DF_HUNT;
            sum_q      <= '0;
            held_q     <= '0;
            held_valid <= 1'b0;
            deliv_cnt  <= '0;
            have_any   <= 1'b0;
            chr_q      <= 1'b0;
            esc_q      <= 1'b0;
            len_q      <= 1'b0;
            pay_data   <= '0;
            pay_valid  <= 1'b0;
            end_pulse  <= 1'b0;
            frame_ok   <= 1'b0;
            err_out    <= '0;
        end else begin
            pay_valid <= 1'b0;
            end_pulse <= 1'b0;
            state     <= state_n;
            if (dec_push) begin
                sum_q      <= sum_q + dec_data;
                held_q     <= dec_data;
                held_valid <= 1'b1;
                if (held_valid) begin
                    if (deliv_cnt < LEN_W'(MAX_LEN)) begin
                        pay_data  <= held_q;
                        pay_valid <= 1'b1;
                        deliv_cnt <= deliv_cnt + LEN_W'(1);
                    end else begin
                        len_q <= 1'b1;
                    end
                end
            end
            if (set_chr) begin
                chr_q      <= 1'b1;
                held_valid <= 1'b0;
            end
            if (set_esc) begin
                esc_q      <= 1'b1;
                held_valid <= 1'b0;
            end
            if (dec_close) begin
                if (have_any) begin
                    end_pulse   <= 1'b1;
                    err_out.chr <= chr_q;
                    err_out.esc <= esc_q || set_esc;
                    err_out.len <= len_q;
                    err_out.sum <= !(chr_q || esc_q || set_esc) && (sum_q != 8'h00);
                    frame_ok    <= !frame_bad && !len_q && (sum_q == 8'h00);
                end
                sum_q      <= '0;
                held_valid <= 1'b0;
                deliv_cnt  <= '0;
                have_any   <= 1'b0;
                chr_q      <= 1'b0;
                esc_q      <= 1'b0;
                len_q      <= 1'b0;
            end else if (ch_valid && state != DF_HUNT) begin
                have_any <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/slip_uart_link.sv
`timescale 1ns/1ps
// Top: SLIP framing over an even-parity UART with only data lines.
// Transmit path: framer -> serializer. Receive path: deserializer -> deframer.
module slip_uart_link
    import slip_link_pkg::*;
#(
    parameter int CLKS_PER_BIT = 8,
    parameter int MAX_LEN      = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    input  logic       tx_last,
    output logic       tx_ready,
    output logic       serial_out,
    input  logic       serial_in,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_frame_end,
    output logic       rx_frame_ok,
    output logic       rx_err_char,
    output logic       rx_err_escape,
    output logic       rx_err_checksum,
    output logic       rx_err_length
);
    logic [7:0] fr_byte;
    logic       fr_valid;
    logic       phy_ready;
    logic       tx_line_busy;
    logic [7:0] ch_data;
    logic       ch_valid;
    logic       ch_err;
    frame_err_t rx_err;

    slip_framer u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_last    (tx_last),
        .tx_ready   (tx_ready),
        .sink_ready (phy_ready),
        .emit_byte  (fr_byte),
        .emit_valid (fr_valid)
    );

    uart_tx_phy #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx_phy (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (fr_byte),
        .in_valid (fr_valid),
        .in_ready (phy_ready),
        .line     (serial_out),
        .busy     (tx_line_busy)
    );

    uart_rx_phy #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx_phy (
        .clk       (clk),
        .rst_n     (rst_n),
        .line      (serial_in),
        .out_data  (ch_data),
        .out_valid (ch_valid),
        .out_err   (ch_err)
    );

    slip_deframer #(.MAX_LEN(MAX_LEN)) u_deframer (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_data   (ch_data),
        .ch_valid  (ch_valid),
        .ch_err    (ch_err),
        .pay_data  (rx_data),
        .pay_valid (rx_valid),
        .end_pulse (rx_frame_end),
        .frame_ok  (rx_frame_ok),
        .err_out   (rx_err)
    );

    assign rx_err_char     = rx_err.chr;
    assign rx_err_escape   = rx_err.esc;
    assign rx_err_checksum = rx_err.sum;
    assign rx_err_length   = rx_err.len;

endmodule

// File: rtl/slip_uart_link_checker.sv
`timescale 1ns/1ps
// Protocol checker for slip_uart_link, attached by bind below.
module slip_uart_link_checker #(
    parameter int MAX_LEN = 16
) (
    input logic clk,
    input logic rst_n,
    input logic tx_valid,
    input logic tx_ready,
    input logic serial_out,
    input logic tx_busy,
    input logic rx_valid,
    input logic rx_frame_end
);
    localparam int SEEN_W = $clog2(MAX_LEN + 2) + 1;

    logic [SEEN_W-1:0] seen;

    // Count bytes delivered since the last frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)            seen <= '0;
        else if (rx_frame_end) seen <= '0;
        else if (rx_valid)     seen <= seen + SEEN_W'(1);
    end

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> serial_out);

    assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !serial_out);

    assert_take_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    assert_end_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_frame_end |=> !rx_frame_end);

    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_frame_end));

    assert_len_cap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        seen <= SEEN_W'(MAX_LEN));

endmodule

bind slip_uart_link slip_uart_link_checker #(.MAX_LEN(MAX_LEN)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_valid     (tx_valid),
    .tx_ready     (tx_ready),
    .serial_out   (serial_out),
    .tx_busy      (tx_line_busy),
    .rx_valid     (rx_valid),
    .rx_frame_end (rx_frame_end)
);

// File: tb/test_slip_uart_link.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module test_slip_uart_link;

    localparam int CPB     = 8;
    localparam int MAXL    = 16;

    typedef logic [7:0] bq_t[$];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_last = 1'b0;
    logic       tx_ready;
    logic       serial_out;
    logic       serial_in;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_frame_end;
    logic       rx_frame_ok;
    logic       rx_err_char;
    logic       rx_err_escape;
    logic       rx_err_checksum;
    logic       rx_err_length;

    logic drv_line = 1'b1;
    logic lb_mode  = 1'b0;
    assign serial_in = lb_mode ? serial_out : drv_line;

    int checks = 0;
    int failures = 0;

    bq_t  cap;
    int   cap_bad = 0;
    logic [7:0] mon_b;
    logic mon_p, mon_s;

    logic [7:0] rxq [$];
    int   ends = 0;
    logic e_ok, e_chr, e_esc, e_sum, e_len;

    always #10 clk = ~clk;

    slip_uart_link #(.CLKS_PER_BIT(CPB), .MAX_LEN(MAXL)) i_slip_uart_link (
        .clk(clk), .rst_n(rst_n),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
        .serial_out(serial_out), .serial_in(serial_in),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_end(rx_frame_end),
        .rx_frame_ok(rx_frame_ok), .rx_err_char(rx_err_char), .rx_err_escape(rx_err_escape),
        .rx_err_checksum(rx_err_checksum), .rx_err_length(rx_err_length)
    );

    task automatic chk(input bit good, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!good) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bq_t esc_byte(input logic [7:0] b);
        bq_t r;
        if (b == 8'hC0)      begin r.push_back(8'hDB); r.push_back(8'hDC); end
        else if (b == 8'hDB) begin r.push_back(8'hDB); r.push_back(8'hDD); end
        else                 r.push_back(b);
        return r;
    endfunction

    // Bench model of the frame encoding (R2, R3, R4).
    function automatic bq_t encode(input bq_t p);
        bq_t r;
        bq_t e;
        logic [7:0] s = 8'h00;
        r.push_back(8'hC0);
        foreach (p[i]) begin
            s = s + p[i];
            e = esc_byte(p[i]);
            foreach (e[j]) r.push_back(e[j]);
        end
        s = 8'h00 - s;
        e = esc_byte(s);
        foreach (e[j]) r.push_back(e[j]);
        r.push_back(8'hC0);
        return r;
    endfunction

    // Decode characters seen on serial_out, checking parity and stop.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && serial_out == 1'b0) begin
                repeat (3) @(negedge clk);
                for (int k = 0; k < 8; k++) begin
                    repeat (CPB) @(negedge clk);
                    mon_b[k] = serial_out;
                end
                repeat (CPB) @(negedge clk);
                mon_p = serial_out;
                repeat (CPB) @(negedge clk);
                mon_s = serial_out;
                cap.push_back(mon_b);
                if (mon_p != ^mon_b || !mon_s) cap_bad++;
            end
        end
    end

    // Record receive-side outputs away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) rxq.push_back(rx_data);
            if (rx_frame_end) begin
                ends++;
                e_ok  = rx_frame_ok;
                e_chr = rx_err_char;
                e_esc = rx_err_escape;
                e_sum = rx_err_checksum;
                e_len = rx_err_length;
            end
        end
    end

    task automatic send_char(input logic [7:0] b, input bit bad_par);
        drv_line = 1'b0;
        repeat (CPB) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            drv_line = b[k];
            repeat (CPB) @(negedge clk);
        end
        drv_line = (^b) ^ bad_par;
        repeat (CPB) @(negedge clk);
        drv_line = 1'b1;
        repeat (CPB + 1) @(negedge clk);
    endtask

    task automatic send_seq(input bq_t s, input int bad_at);
        foreach (s[i]) send_char(s[i], i == bad_at);
        repeat (30) @(negedge clk);
    endtask

    task automatic drive_tx(input bq_t p);
        foreach (p[i]) begin
            tx_data  = p[i];
            tx_last  = (i == p.size() - 1);
            tx_valid = 1'b1;
            #1;
            while (!tx_ready) begin
                @(negedge clk);
                #1;
            end
            @(negedge clk);
        end
        tx_valid = 1'b0;
        tx_last  = 1'b0;
    endtask

    task automatic tx_case(input string req, input bq_t p);
        bq_t exp;
        exp = encode(p);
        cap.delete();
        cap_bad = 0;
        drive_tx(p);
        repeat ((exp.size() + 2) * 11 * CPB) @(negedge clk);
        chk(cap.size() == exp.size(), req, "tx byte count", cap.size(), exp.size());
        foreach (exp[i])
            if (i < cap.size()) chk(cap[i] == exp[i], req, $sformatf("tx byte %0d", i), cap[i], exp[i]);
        chk(cap_bad == 0, "R1", "parity/stop errors on line", cap_bad, 0);
    endtask

    task automatic t_reset;
        chk(serial_out == 1'b1, "R13", "serial_out in reset", serial_out, 1);
        chk(tx_ready == 1'b0, "R13", "tx_ready in reset", tx_ready, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(serial_out == 1'b1, "R13", "serial_out after reset", serial_out, 1);
        chk(tx_ready == 1'b0, "R13", "tx_ready idle", tx_ready, 0);
        chk(ends == 0 && rxq.size() == 0, "R13", "no rx pulses", ends, 0);
    endtask

    task automatic t_tx_plain;
        tx_case("R2", '{8'h01, 8'h02, 8'h03});
        chk(cap.size() > 4 && cap[4] == 8'hFA, "R4", "checksum byte", cap.size() > 4 ? cap[4] : 0, 8'hFA);
    endtask

    task automatic t_tx_escape;
        tx_case("R3", '{8'hC0, 8'hDB, 8'h10});
        tx_case("R3", '{8'h40});
    endtask

    task automatic t_rx_good;
        bq_t s;
        rxq.delete();
        s = encode('{8'h11, 8'h22, 8'h33});
        s.push_front(8'h77);
        send_seq(s, -1);
        chk(ends == 1, "R12", "frame ends", ends, 1);
        chk(rxq.size() == 3, "R4", "payload count", rxq.size(), 3);
        if (rxq.size() == 3) begin
            chk(rxq[0] == 8'h11, "R6", "byte 0", rxq[0], 8'h11);
            chk(rxq[2] == 8'h33, "R6", "byte 2", rxq[2], 8'h33);
        end
        chk(e_ok == 1'b1, "R4", "frame ok", e_ok, 1);
    endtask

    task automatic t_rx_escape;
        rxq.delete();
        send_seq(encode('{8'hC0, 8'hDB, 8'h05}), -1);
        chk(rxq.size() == 3, "R3", "payload count", rxq.size(), 3);
        if (rxq.size() == 3) begin
            chk(rxq[0] == 8'hC0, "R3", "unescaped C0", rxq[0], 8'hC0);
            chk(rxq[1] == 8'hDB, "R3", "unescaped DB", rxq[1], 8'hDB);
        end
        chk(e_ok == 1'b1, "R3", "frame ok", e_ok, 1);
    endtask

    task automatic t_rx_bad_sum;
        int e0;
        e0 = ends;
        send_seq('{8'hC0, 8'h01, 8'h02, 8'h00, 8'hC0}, -1);
        chk(ends == e0 + 1, "R9", "frame end", ends, e0 + 1);
        chk(e_sum == 1'b1 && e_ok == 1'b0, "R9", "checksum error", {e_sum, e_ok}, 2'b10);
    endtask

    task automatic t_rx_parity;
        rxq.delete();
        send_seq('{8'hC0, 8'h01, 8'h02, 8'h03, 8'hFA, 8'hC0}, 2);
        chk(e_chr == 1'b1 && e_ok == 1'b0, "R7", "char error", {e_chr, e_ok}, 2'b10);
        chk(rxq.size() == 0, "R7", "bytes delivered after error", rxq.size(), 0);
        send_seq(encode('{8'h09}), -1);
        chk(e_ok == 1'b1 && e_chr == 1'b0, "R7", "resync frame ok", {e_ok, e_chr}, 2'b10);
        chk(rxq.size() == 1 && rxq[0] == 8'h09, "R7", "resync payload", rxq.size(), 1);
    endtask

    task automatic t_rx_bad_escape;
        send_seq('{8'hC0, 8'h01, 8'hDB, 8'h41, 8'h02, 8'hC0}, -1);
        chk(e_esc == 1'b1 && e_ok == 1'b0, "R8", "escape error", {e_esc, e_ok}, 2'b10);
    endtask

    task automatic t_rx_empty;
        int e0;
        e0 = ends;
        rxq.delete();
        send_seq('{8'hC0, 8'hC0, 8'hC0, 8'hC0}, -1);
        chk(ends == e0, "R10", "no frame end", ends, e0);
        chk(rxq.size() == 0, "R10", "no payload", rxq.size(), 0);
    endtask

    task automatic t_rx_length;
        bq_t p;
        for (int i = 0; i < MAXL + 2; i++) p.push_back(8'h01);
        rxq.delete();
        send_seq(encode(p), -1);
        chk(rxq.size() == MAXL, "R11", "delivered count", rxq.size(), MAXL);
        chk(e_len == 1'b1, "R11", "length flag", e_len, 1);
        chk(e_sum == 1'b0 && e_ok == 1'b0, "R11", "sum ok, frame bad", {e_sum, e_ok}, 2'b00);
    endtask

    task automatic t_loopback;
        rxq.delete();
        lb_mode = 1'b1;
        repeat (4) @(negedge clk);
        tx_case("R2", '{8'hC0, 8'h7E, 8'hDB});
        repeat (40) @(negedge clk);
        lb_mode = 1'b0;
        chk(rxq.size() == 3, "R6", "loopback count", rxq.size(), 3);
        if (rxq.size() == 3) chk(rxq[2] == 8'hDB, "R3", "loopback byte 2", rxq[2], 8'hDB);
        chk(e_ok == 1'b1, "R5", "loopback frame ok", e_ok, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_tx_plain();
        t_tx_escape();
        t_rx_good();
        t_rx_escape();
        t_rx_bad_sum();
        t_rx_parity();
        t_rx_bad_escape();
        t_rx_empty();
        t_rx_length();
        t_loopback();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule